// File: doc/BRIEF.md
# Write dirty-granule tracker

This block records which fixed-size regions of a set of memory banks have been written since a downstream consumer last copied them. Bank writes arrive as a strobe with a bank select mask and a byte offset inside the bank. The offset is divided into 512-byte granules, and each granule has one dirty bit. A consumer that keeps a flat shadow copy of the banks scans the dirty set through a single port. The port shows the lowest dirty granule. When the consumer acknowledges it, that bit is cleared, so only modified regions are copied again.

Two small memories of 2 KB each are tracked beside the banks. The palette memory has four 512-byte flags, and the object attribute memory has two 1 KB flags. Both have per-flag clear inputs. Writes made through the secondary processor window still reach memory, but they leave the dirty state untouched. After reset, every flag is set, so the consumer's first pass copies everything. This matches a mapping snapshot that starts at a value no real bank can have.

Top module: `dgt_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every bank granule bit and every palette and attribute flag is set, and the scan port shows valid with index 0.
- R2: A tracked bank write sets the bit at flat index bank*64 + offset[14:9], where offset is the 15-bit byte offset and each bank holds 64 granules of 512 bytes.
- R3: A bank write with several bits set in the 4-bit bank mask (bit b selects bank b) sets the same granule bit in every selected bank.
- R4: A palette write uses only the low 11 bits of its 16-bit address and sets palette flag address[10:9].
- R5: An attribute write uses only the low 11 bits of its 16-bit address and sets attribute flag address[10].
- R6: A bank write that has the secondary-window input high sets no dirty bit.
- R7: The scan port shows the lowest set flat index, with valid high. When no bank bit is set, valid is low.
- R8: Acknowledging while valid is high clears the reported bit, and the next index appears on the following cycle.
- R9: When a set and a clear reach the same bit in the same cycle, the bit stays set. This holds for a scan acknowledge and also for a palette or attribute clear.
- R10: Each bit of the palette clear input and of the attribute clear input clears the flag at the same position.
- R11: Every set and every clear takes effect at the clock edge where it is sampled, and the outputs show it right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bwr_valid_i | input | 1 | Bank write strobe |
| bwr_bank_i | input | 4 | Bank select mask, one bit per bank |
| bwr_off_i | input | 15 | Byte offset inside the bank |
| bwr_secondary_i | input | 1 | Write comes through the secondary window (untracked) |
| pal_wr_i | input | 1 | Palette write strobe |
| pal_addr_i | input | 16 | Palette byte address |
| pal_clr_i | input | 4 | Palette flag clear mask |
| attr_wr_i | input | 1 | Attribute write strobe |
| attr_addr_i | input | 16 | Attribute byte address |
| attr_clr_i | input | 2 | Attribute flag clear mask |
| scan_ack_i | input | 1 | Acknowledge and clear the reported granule |
| scan_valid_o | output | 1 | A bank granule is dirty |
| scan_idx_o | output | 8 | Lowest dirty flat index {bank, granule} |
| pal_dirty_o | output | 4 | Palette dirty flags |
| attr_dirty_o | output | 2 | Attribute dirty flags |

## Verification
All state sits in one register stage, and the outputs are driven combinationally from it. A write, clear or acknowledge sampled at one rising edge is therefore visible right after that edge, and it must not be visible before. The bench drives inputs at the falling edge and updates its behavioural model at the rising edge from the values it drove. It compares the scan outputs and both flag vectors at the next falling edge. Each comparison is made exactly one edge after the stimulus, and every cycle is checked, including cycles where writes and clears collide.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
  localparam int unsigned BANK_GRAN_BYTES = 512;
  localparam int unsigned PAL_GRAN_BYTES  = 512;
  localparam int unsigned ATTR_GRAN_BYTES = 1024;
  localparam int unsigned SMALL_MEM_BYTES = 2048;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_TRACK = 2'd1,
    SRC_SKIP  = 2'd2
  } wr_src_e;
endpackage

// File: rtl/dgt_prio_enc.sv
module dgt_prio_enc #(
  parameter int unsigned W     = 256,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = |vec_i;
    idx_o   = '0;
    // scan from the top so the lowest set bit wins
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dgt_bank_array.sv
module dgt_bank_array #(
  parameter int unsigned NB     = 4,
  parameter int unsigned GRANS  = 64,
  localparam int unsigned BANK_W = $clog2(NB),
  localparam int unsigned GIDX_W = $clog2(GRANS),
  localparam int unsigned IDX_W  = BANK_W + GIDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_en_i,
  input  logic [NB-1:0]       set_mask_i,
  input  logic [GIDX_W-1:0]   set_gran_i,
  input  logic                clr_en_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  output logic [NB*GRANS-1:0] dirty_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [GRANS-1:0] row_q, row_d;
    logic             clr_hit;

    assign clr_hit = clr_en_i && (clr_idx_i[IDX_W-1:GIDX_W] == BANK_W'(b));

    always_comb begin
      row_d = row_q;
      if (clr_hit) row_d[clr_idx_i[GIDX_W-1:0]] = 1'b0;
      // set applied last: set wins on collision
      if (set_en_i && set_mask_i[b]) row_d[set_gran_i] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q <= '1;
      else         row_q <= row_d;
    end

    assign dirty_o[b*GRANS +: GRANS] = row_q;
  end
endmodule

// File: rtl/dgt_small_tracker.sv
module dgt_small_tracker #(
  parameter int unsigned MEM_BYTES  = 2048,
  parameter int unsigned GRAN_BYTES = 512,
  parameter int unsigned ADDR_W     = 16,
  localparam int unsigned N         = MEM_BYTES / GRAN_BYTES,
  localparam int unsigned MEM_LG    = $clog2(MEM_BYTES),
  localparam int unsigned GRAN_LG   = $clog2(GRAN_BYTES),
  localparam int unsigned SEL_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      clr_i,
  output logic [N-1:0]      dirty_o
);
  logic [N-1:0]     flag_q, flag_d;
  logic [SEL_W-1:0] sel;

  // address wraps at the memory size; upper bits ignored
  assign sel = SEL_W'(addr_i[MEM_LG-1:GRAN_LG]);

  always_comb begin
    flag_d = flag_q & ~clr_i;
    if (wr_i) flag_d[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '1;
    else         flag_q <= flag_d;
  end

  assign dirty_o = flag_q;
endmodule

// File: rtl/dgt_top.sv
module dgt_top
  import dgt_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_BYTES = 32768,
  parameter int unsigned ADDR_W     = 16,
  localparam int unsigned OFF_W     = $clog2(BANK_BYTES),
  localparam int unsigned GRANS     = BANK_BYTES / BANK_GRAN_BYTES,
  localparam int unsigned GRAN_LG   = $clog2(BANK_GRAN_BYTES),
  localparam int unsigned GIDX_W    = $clog2(GRANS),
  localparam int unsigned FLAT      = NUM_BANKS * GRANS,
  localparam int unsigned IDX_W     = $clog2(FLAT),
  localparam int unsigned PAL_N     = SMALL_MEM_BYTES / PAL_GRAN_BYTES,
  localparam int unsigned ATTR_N    = SMALL_MEM_BYTES / ATTR_GRAN_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bwr_valid_i,
  input  logic [NUM_BANKS-1:0] bwr_bank_i,
  input  logic [OFF_W-1:0]     bwr_off_i,
  input  logic                 bwr_secondary_i,
  input  logic                 pal_wr_i,
  input  logic [ADDR_W-1:0]    pal_addr_i,
  input  logic [PAL_N-1:0]     pal_clr_i,
  input  logic                 attr_wr_i,
  input  logic [ADDR_W-1:0]    attr_addr_i,
  input  logic [ATTR_N-1:0]    attr_clr_i,
  input  logic                 scan_ack_i,
  output logic                 scan_valid_o,
  output logic [IDX_W-1:0]     scan_idx_o,
  output logic [PAL_N-1:0]     pal_dirty_o,
  output logic [ATTR_N-1:0]    attr_dirty_o
);
  wr_src_e           src;
  logic              set_en;
  logic [GIDX_W-1:0] set_gran;
  logic              clr_en;
  logic [FLAT-1:0]   bank_dirty;

  always_comb begin
    if (!bwr_valid_i)        src = SRC_NONE;
    else if (bwr_secondary_i) src = SRC_SKIP;
    else                     src = SRC_TRACK;
  end

  assign set_en   = (src == SRC_TRACK);
  assign set_gran = bwr_off_i[OFF_W-1:GRAN_LG];
  assign clr_en   = scan_ack_i && scan_valid_o;

  dgt_bank_array #(
    .NB    (NUM_BANKS),
    .GRANS (GRANS)
  ) u_banks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (set_en),
    .set_mask_i (bwr_bank_i),
    .set_gran_i (set_gran),
    .clr_en_i   (clr_en),
    .clr_idx_i  (scan_idx_o),
    .dirty_o    (bank_dirty)
  );

  dgt_prio_enc #(
    .W     (FLAT),
    .IDX_W (IDX_W)
  ) u_scan (
    .vec_i   (bank_dirty),
    .valid_o (scan_valid_o),
    .idx_o   (scan_idx_o)
  );

  dgt_small_tracker #(
    .MEM_BYTES  (SMALL_MEM_BYTES),
    .GRAN_BYTES (PAL_GRAN_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_pal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (pal_wr_i),
    .addr_i  (pal_addr_i),
    .clr_i   (pal_clr_i),
    .dirty_o (pal_dirty_o)
  );

  dgt_small_tracker #(
    .MEM_BYTES  (SMALL_MEM_BYTES),
    .GRAN_BYTES (ATTR_GRAN_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_attr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (attr_wr_i),
    .addr_i  (attr_addr_i),
    .clr_i   (attr_clr_i),
    .dirty_o (attr_dirty_o)
  );
endmodule

// File: rtl/dgt_checker.sv
module dgt_checker #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned OFF_W     = 15,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned PAL_N     = 4,
  parameter int unsigned ATTR_N    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bwr_valid_i,
  input logic [NUM_BANKS-1:0] bwr_bank_i,
  input logic                 bwr_secondary_i,
  input logic                 pal_wr_i,
  input logic [ADDR_W-1:0]    pal_addr_i,
  input logic [PAL_N-1:0]     pal_clr_i,
  input logic                 attr_wr_i,
  input logic [ADDR_W-1:0]    attr_addr_i,
  input logic                 scan_ack_i,
  input logic                 scan_valid_o,
  input logic [IDX_W-1:0]     scan_idx_o,
  input logic [PAL_N-1:0]     pal_dirty_o,
  input logic [ATTR_N-1:0]    attr_dirty_o
);
  AST_WRITE_MAKES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bwr_valid_i && !bwr_secondary_i && (|bwr_bank_i)) |=> scan_valid_o); // R2

  AST_SKIP_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!bwr_valid_i || bwr_secondary_i) && !scan_ack_i)
      |=> ($stable(scan_valid_o) && $stable(scan_idx_o))); // R6

  AST_ACK_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_ack_i && scan_valid_o && !bwr_valid_i)
      |=> (!scan_valid_o || (scan_idx_o > $past(scan_idx_o)))); // R8

  AST_PAL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_wr_i |=> pal_dirty_o[$past(pal_addr_i[10:9])]); // R4

  AST_ATTR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_wr_i |=> attr_dirty_o[$past(attr_addr_i[10])]); // R5

  AST_PAL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|pal_clr_i) && !pal_wr_i) |=> ((pal_dirty_o & $past(pal_clr_i)) == '0)); // R10
endmodule

bind dgt_top dgt_checker #(
  .NUM_BANKS (NUM_BANKS),
  .OFF_W     (OFF_W),
  .ADDR_W    (ADDR_W),
  .IDX_W     (IDX_W),
  .PAL_N     (PAL_N),
  .ATTR_N    (ATTR_N)
) u_dgt_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .bwr_valid_i     (bwr_valid_i),
  .bwr_bank_i      (bwr_bank_i),
  .bwr_secondary_i (bwr_secondary_i),
  .pal_wr_i        (pal_wr_i),
  .pal_addr_i      (pal_addr_i),
  .pal_clr_i       (pal_clr_i),
  .attr_wr_i       (attr_wr_i),
  .attr_addr_i     (attr_addr_i),
  .scan_ack_i      (scan_ack_i),
  .scan_valid_o    (scan_valid_o),
  .scan_idx_o      (scan_idx_o),
  .pal_dirty_o     (pal_dirty_o),
  .attr_dirty_o    (attr_dirty_o)
);

// File: tb/dgt_top_tb_top.sv
module dgt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB    = 4;
  localparam int GR    = 64;
  localparam int FLATN = NB * GR;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bwr_valid_i = 1'b0;
  logic [3:0]  bwr_bank_i = '0;
  logic [14:0] bwr_off_i = '0;
  logic        bwr_secondary_i = 1'b0;
  logic        pal_wr_i = 1'b0;
  logic [15:0] pal_addr_i = '0;
  logic [3:0]  pal_clr_i = '0;
  logic        attr_wr_i = 1'b0;
  logic [15:0] attr_addr_i = '0;
  logic [1:0]  attr_clr_i = '0;
  logic        scan_ack_i = 1'b0;
  logic        scan_valid_o;
  logic [7:0]  scan_idx_o;
  logic [3:0]  pal_dirty_o;
  logic [1:0]  attr_dirty_o;

  int n_checks = 0;
  int n_fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  bit m_bank [FLATN];
  bit [3:0] m_pal;
  bit [1:0] m_attr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dgt_top dut_i (
    .clk_i, .rst_ni, .bwr_valid_i, .bwr_bank_i, .bwr_off_i, .bwr_secondary_i,
    .pal_wr_i, .pal_addr_i, .pal_clr_i, .attr_wr_i, .attr_addr_i, .attr_clr_i,
    .scan_ack_i, .scan_valid_o, .scan_idx_o, .pal_dirty_o, .attr_dirty_o
  );

  function automatic int lowest();
    for (int i = 0; i < FLATN; i++) if (m_bank[i]) return i;
    return -1;
  endfunction

  // behavioural model: clears from pre-state, then sets (set wins, R9)
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FLATN; i++) m_bank[i] = 1'b1;
      m_pal  = '1;
      m_attr = '1;
    end else begin
      int lo;
      lo = lowest();
      if (scan_ack_i && lo >= 0) m_bank[lo] = 1'b0;
      m_pal  = m_pal & ~pal_clr_i;
      m_attr = m_attr & ~attr_clr_i;
      if (bwr_valid_i && !bwr_secondary_i)
        for (int b = 0; b < NB; b++)
          if (bwr_bank_i[b]) m_bank[b*GR + int'(bwr_off_i[14:9])] = 1'b1;
      if (pal_wr_i)  m_pal[pal_addr_i[10:9]] = 1'b1;
      if (attr_wr_i) m_attr[attr_addr_i[10]] = 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int lo;
    lo = lowest();
    chk(cur_req, "scan_valid", int'(scan_valid_o), int'(lo >= 0));
    if (lo >= 0) chk(cur_req, "scan_idx", int'(scan_idx_o), lo);
    chk(cur_req, "pal_dirty", int'(pal_dirty_o), int'(m_pal));
    chk(cur_req, "attr_dirty", int'(attr_dirty_o), int'(m_attr));
  endtask

  task automatic idle_inputs();
    bwr_valid_i = 0; bwr_bank_i = '0; bwr_off_i = '0; bwr_secondary_i = 0;
    pal_wr_i = 0; pal_clr_i = '0; attr_wr_i = 0; attr_clr_i = '0; scan_ack_i = 0;
  endtask

  // one clock: model updates at posedge, compare at next negedge (R11)
  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
    idle_inputs();
  endtask

  task automatic bwrite(input logic [3:0] mask, input logic [14:0] off, input bit sec);
    bwr_valid_i = 1; bwr_bank_i = mask; bwr_off_i = off; bwr_secondary_i = sec;
    cyc();
  endtask

  task automatic drain();
    for (int k = 0; k < FLATN + 2; k++) begin
      scan_ack_i = 1;
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    compare();
    chk("R1", "reset scan_idx", int'(scan_idx_o), 0);
    rst_ni = 1'b1;
    cyc();
    chk("R1", "post-reset pal all set", int'(pal_dirty_o), 15);

    cur_req = "R8";
    drain();
    cur_req = "R7";
    chk("R7", "empty valid low", int'(scan_valid_o), 0);

    cur_req = "R2";
    bwrite(4'b0100, 15'h0A00, 0);  // bank 2, granule 5 -> 133
    chk("R2", "single write idx", int'(scan_idx_o), 133);
    bwrite(4'b0001, 15'h7FFF, 0);  // bank 0, granule 63
    chk("R2", "top granule idx", int'(scan_idx_o), 63);
    drain();

    cur_req = "R3";
    bwrite(4'b1011, 15'h0200, 0);  // granule 1 in banks 0,1,3
    chk("R3", "broadcast first", int'(scan_idx_o), 1);
    scan_ack_i = 1; cyc();
    chk("R3", "broadcast second", int'(scan_idx_o), 65);
    scan_ack_i = 1; cyc();
    chk("R3", "broadcast third", int'(scan_idx_o), 193);
    drain();

    cur_req = "R6";
    bwrite(4'b1111, 15'h1234, 1);
    chk("R6", "secondary leaves empty", int'(scan_valid_o), 0);

    cur_req = "R10";
    pal_clr_i = 4'hF; attr_clr_i = 2'b11; cyc();
    chk("R10", "pal cleared", int'(pal_dirty_o), 0);
    chk("R10", "attr cleared", int'(attr_dirty_o), 0);

    cur_req = "R4";
    pal_wr_i = 1; pal_addr_i = 16'hF9FF; cyc();  // masked 0x1FF -> flag 0
    chk("R4", "masked pal flag", int'(pal_dirty_o), 1);
    pal_wr_i = 1; pal_addr_i = 16'h0600; cyc();  // flag 3
    chk("R4", "pal flag 3", int'(pal_dirty_o), 9);

    cur_req = "R5";
    attr_wr_i = 1; attr_addr_i = 16'hFBFF; cyc(); // masked 0x3FF -> flag 0
    chk("R5", "masked attr flag", int'(attr_dirty_o), 1);
    attr_wr_i = 1; attr_addr_i = 16'h0400; cyc(); // flag 1
    chk("R5", "attr flag 1", int'(attr_dirty_o), 3);

    cur_req = "R9";
    bwrite(4'b0010, 15'h0000, 0);  // idx 64
    scan_ack_i = 1; bwr_valid_i = 1; bwr_bank_i = 4'b0010; bwr_off_i = 15'h0000; cyc();
    chk("R9", "set wins over ack", int'(scan_idx_o), 64);
    pal_clr_i = 4'b0001; pal_wr_i = 1; pal_addr_i = 16'h0000; cyc();
    chk("R9", "pal set wins", int'(pal_dirty_o[0]), 1);
    attr_clr_i = 2'b10; attr_wr_i = 1; attr_addr_i = 16'h0400; cyc();
    chk("R9", "attr set wins", int'(attr_dirty_o[1]), 1);
    drain();

    cur_req = "R11";
    for (int k = 0; k < 3000; k++) begin
      bwr_valid_i     = ($urandom % 3) == 0;
      bwr_bank_i      = 4'($urandom);
      bwr_off_i       = 15'($urandom);
      bwr_secondary_i = ($urandom % 4) == 0;
      pal_wr_i        = ($urandom % 5) == 0;
      pal_addr_i      = 16'($urandom);
      pal_clr_i       = ($urandom % 4) == 0 ? 4'($urandom) : 4'h0;
      attr_wr_i       = ($urandom % 5) == 0;
      attr_addr_i     = 16'($urandom);
      attr_clr_i      = ($urandom % 4) == 0 ? 2'($urandom) : 2'h0;
      scan_ack_i      = ($urandom % 2) == 0;
      cyc();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule